// File: doc/BRIEF.md
# MDIO Station Management Master

This block is a management-bus master that lets a processor read and write registers in an external Ethernet PHY. Software programs a control word with the PHY address, the register address, an operation select bit and a clock-range code. A separate 16-bit data word holds the value to send or, after a read, the value returned. Setting the busy bit in the control word launches a transfer.

The block divides the system clock down to an MDC clock whose rate depends on the range code. It then shifts out a Clause 22 frame on MDIO: preamble, start, opcode, both addresses, turnaround and 16 data bits. An output enable lets the board share the single bidirectional MDIO line. During a read the master lets go of the line for turnaround and data, and it captures the bits the PHY returns. Both registers are frozen while a transfer is in flight. Busy drops when the frame ends.

Control word layout: bit 0 busy/start, bit 1 write-select, bits 4:2 clock-range code, bit 5 reads 0, bits 10:6 PHY register address, bits 15:11 PHY address.

Top module: `mdio_mgmt`

## Requirements
- R1: Writing the control word with bit 0 set while idle starts a transfer. Bit 0 then reads 1 for exactly 128 × H system clocks, where H is the half-period chosen by the range code, and hardware clears it at the end.
- R2: While bit 0 reads 1, writes to the control word and to the data word are ignored. This includes a second start.
- R3: Write-select bit 1 = 1 performs a PHY register write, and 0 performs a PHY register read.
- R4: Range code 000 gives an MDC period of 42 system clocks, 001 gives 62, 010 gives 16 and 011 gives 26. Each period is high and low for half of it.
- R5: Range codes 100 to 111 give an MDC period of 62 system clocks.
- R6: Each frame, in MDC order, is 32 ones, start 01, opcode (01 write, 10 read), 5-bit PHY address MSB first, 5-bit register address MSB first, 2 turnaround bits and 16 data bits MSB first.
- R7: On a write the turnaround is driven as 10, and the output enable stays high for all 64 bits.
- R8: On a read the output enable is high for the first 46 bits and low from the turnaround to the end of the frame. The data bits are sampled on MDC rising edges, MSB first.
- R9: When a read completes, the captured 16 bits appear in the data word by the time bit 0 reads 0.
- R10: MDC is low and the output enable is low whenever no transfer is in flight.
- R11: Register addresses 16 to 31 are framed exactly like 0 to 15.
- R12: A control-word write with bit 0 clear updates the fields but starts no transfer.
- R13: Each MDIO bit changes right after an MDC rising edge and is stable through the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write value |
| cfg_rdata | output | 16 | Control word readback |
| dat_we | input | 1 | Data word write strobe |
| dat_wdata | input | 16 | Data word write value |
| dat_rdata | output | 16 | Data word readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The vector table runs writes and reads under every range code, including two reserved codes. This separates the four divider values and the fallback, and it shows whether the opcode and turnaround follow the select bit. The addresses and data words mix all-ones, all-zeros, single-bit and alternating patterns, with register addresses on both sides of 16, so bit-order and field-position faults show up in the captured frame. The directed tests cover three more cases: register writes issued mid-transfer, including a second start; a field update with the start bit clear; and the idle line state after each frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int FRAME_LEN  = 64;
    localparam int IDX_W      = $clog2(FRAME_LEN);
    localparam int DATA_W     = 16;
    localparam int TA_POS     = 46;
    localparam int DATA_POS   = 48;
    localparam int HALF_W     = 6;

    typedef struct packed {
        logic [4:0] phy;
        logic [4:0] regad;
        logic       rsvd;
        logic [2:0] range;
        logic       wr;
        logic       busy;
    } cfg_t;

    function automatic logic [HALF_W-1:0] half_period(input logic [2:0] code);
        case (code)
            3'b000:  return HALF_W'(21);
            3'b001:  return HALF_W'(31);
            3'b010:  return HALF_W'(8);
            3'b011:  return HALF_W'(13);
            default: return HALF_W'(31);
        endcase
    endfunction

    function automatic logic [FRAME_LEN-1:0] build_frame(input cfg_t c,
                                                         input logic [DATA_W-1:0] d);
        logic [1:0] op;
        logic [1:0] ta;
        op = c.wr ? 2'b01 : 2'b10;
        ta = c.wr ? 2'b10 : 2'b00;
        return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regad, ta, d};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] half,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [CNT_W-1:0] cnt;
    logic             term;

    assign term = run && (cnt == half - 1'b1);
    assign rise = term && !mdc;
    assign fall = term && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (term) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_mgmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic [FRAME_LEN-1:0] frame,
    input  logic                 is_wr,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 mdio_i,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 done,
    output logic [DATA_W-1:0]    rdata
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    logic [IDX_W-1:0]  idx;
    logic              last;
    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            idx  <= '0;
            last <= 1'b0;
        end else if (rise) begin
            if (idx == LAST_IDX) last <= 1'b1;
            else                 idx  <= idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (run && rise && !is_wr && !last && idx >= IDX_W'(DATA_POS)) begin
            shreg <= {shreg[DATA_W-2:0], mdio_i};
        end
    end

    assign mdio_o  = run && frame[LAST_IDX - idx];
    assign mdio_oe = run && (is_wr || idx < IDX_W'(TA_POS));
    assign done    = run && last && fall;
    assign rdata   = shreg;
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata,
    input  logic        dat_we,
    input  logic [15:0] dat_wdata,
    output logic [15:0] dat_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    cfg_t                 cfg;
    cfg_t                 cfg_in;
    logic [DATA_W-1:0]    dat;
    logic [DATA_W-1:0]    rd_cap;
    logic [FRAME_LEN-1:0] frame;
    logic                 rise, fall, done;

    assign cfg_in = cfg_t'(cfg_wdata);
    assign frame  = build_frame(cfg, dat);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            dat <= '0;
        end else if (cfg.busy) begin
            if (done) begin
                cfg.busy <= 1'b0;
                if (!cfg.wr) dat <= rd_cap;
            end
        end else begin
            if (cfg_we) begin
                cfg      <= cfg_in;
                cfg.rsvd <= 1'b0;
            end
            if (dat_we) dat <= dat_wdata;
        end
    end

    mdio_mdc_gen #(.CNT_W(HALF_W)) u_mdc (
        .clk  (clk),
        .rst  (rst),
        .run  (cfg.busy),
        .half (half_period(cfg.range)),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_frame_eng u_eng (
        .clk     (clk),
        .rst     (rst),
        .run     (cfg.busy),
        .frame   (frame),
        .is_wr   (cfg.wr),
        .rise    (rise),
        .fall    (fall),
        .mdio_i  (mdio_i),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done    (done),
        .rdata   (rd_cap)
    );

    assign cfg_rdata = cfg;
    assign dat_rdata = dat;
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic        dat_we,
    input logic [15:0] cfg_rdata,
    input logic [15:0] dat_rdata,
    input logic        mdc,
    input logic        mdio_oe
);
    assert_lock_cfg_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[0] && cfg_we) |=> (cfg_rdata[15:1] == $past(cfg_rdata[15:1])));

    assert_lock_dat_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[0] && cfg_rdata[1] && dat_we) |=> $stable(dat_rdata));

    assert_start_src_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_rdata[0]) |-> $past(cfg_we));

    assert_idle_oe_R10: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[0] |-> !mdio_oe);

    assert_idle_mdc_R10: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[0] |-> !mdc);

    assert_wr_drive_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[0] && cfg_rdata[1]) |-> mdio_oe);
endmodule

bind mdio_mgmt mdio_mgmt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .dat_we    (dat_we),
    .cfg_rdata (cfg_rdata),
    .dat_rdata (dat_rdata),
    .mdc       (mdc),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_mgmt_tb.sv
module mdio_mgmt_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    // {code[45:43], wr[42], phy[41:37], reg[36:32], wdata[31:16], phy_reply[15:0]}
    localparam logic [45:0] VECS [NVEC] = '{
        {3'b000, 1'b1, 5'h01, 5'h03, 16'hA5C3, 16'h0000},
        {3'b001, 1'b0, 5'h1F, 5'h11, 16'h0000, 16'hBEEF},
        {3'b010, 1'b1, 5'h00, 5'h1F, 16'hFFFF, 16'h0000},
        {3'b011, 1'b0, 5'h05, 5'h00, 16'h0000, 16'h8001},
        {3'b100, 1'b1, 5'h0A, 5'h15, 16'h1234, 16'h0000},
        {3'b111, 1'b0, 5'h12, 5'h10, 16'h0000, 16'h5A5A}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0, dat_we = 1'b0, mdio_i = 1'b1;
    logic [15:0] cfg_wdata = '0, dat_wdata = '0;
    logic [15:0] cfg_rdata, dat_rdata;
    logic mdc, mdio_o, mdio_oe;

    int checks = 0;
    int errors = 0;

    logic [63:0] cap_o, cap_oe;
    int busy_cycles, rise_t0, rise_t1;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt u_dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int exp_period(input logic [2:0] code);
        case (code)
            3'b000: return 42;
            3'b001: return 62;
            3'b010: return 16;
            3'b011: return 26;
            default: return 62;
        endcase
    endfunction

    function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] phy,
                                              input logic [4:0] ra, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra,
                (wr ? 2'b10 : 2'b00), d};
    endfunction

    // Starts a transfer and plays the PHY side; optionally pokes registers mid-flight.
    task automatic run_xfer(input logic [15:0] cw, input logic [15:0] reply,
                            input bit poke);
        int k = 0;
        int t = 0;
        logic prev = 1'b0;
        logic lo_o = 1'b0, lo_oe = 1'b0;
        bit cfg_ok = 1'b1;
        cap_o = '0; cap_oe = '0; busy_cycles = 0; rise_t0 = -1; rise_t1 = -1;
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = cw;
        @(negedge clk);
        cfg_we = 1'b0;
        while (cfg_rdata[0] && t < 20000) begin
            t++;
            busy_cycles++;
            if (mdc && !prev) begin
                if (k < 64) begin
                    cap_o[63-k]  = lo_o;
                    cap_oe[63-k] = lo_oe;
                end
                if (rise_t0 < 0) rise_t0 = t;
                else if (rise_t1 < 0) rise_t1 = t;
                k++;
            end
            // R13: mdio_o must not move while MDC stays low
            if (!mdc && !prev && t > 1 && mdio_o !== lo_o) cfg_ok = 1'b0;
            if (!mdc) begin
                lo_o = mdio_o; lo_oe = mdio_oe;
                mdio_i = (k >= 48 && k < 64) ? reply[63-k] : 1'b1;
            end
            prev = mdc;
            cfg_we = 1'b0; dat_we = 1'b0;
            if (poke && busy_cycles == 10) begin
                cfg_we = 1'b1; cfg_wdata = 16'hFFFF;
                dat_we = 1'b1; dat_wdata = 16'h0F0F;
            end
            @(negedge clk);
        end
        cfg_we = 1'b0; dat_we = 1'b0;
        if (t >= 20000) check(1'b0, "watchdog R1", t, 20000);
        check(cfg_ok, "R13 bit stable during MDC low", 0, 0);
        check(k == 64, "R6 rising edge count", k, 64);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state (R10)
        check(cfg_rdata == 16'h0 && dat_rdata == 16'h0, "reset regs R10",
              {cfg_rdata, dat_rdata}, 0);
        check(!mdc && !mdio_oe, "reset line R10", {mdc, mdio_oe}, 0);

        for (int v = 0; v < NVEC; v++) begin
            logic [2:0]  code  = VECS[v][45:43];
            logic        wr    = VECS[v][42];
            logic [4:0]  phy   = VECS[v][41:37];
            logic [4:0]  ra    = VECS[v][36:32];
            logic [15:0] wd    = VECS[v][31:16];
            logic [15:0] rp    = VECS[v][15:0];
            logic [63:0] ef    = exp_frame(wr, phy, ra, wd);
            logic [63:0] eoe   = wr ? '1 : {46'h3FFF_FFFF_FFFF, 18'h0};
            logic [63:0] mask  = wr ? '1 : {46'h3FFF_FFFF_FFFF, 18'h0};
            int          per   = exp_period(code);
            @(negedge clk);
            dat_we = 1'b1; dat_wdata = wd;
            @(negedge clk);
            dat_we = 1'b0;
            run_xfer({phy, ra, 1'b0, code, wr, 1'b1}, rp, 1'b0);
            // R1 duration, R4/R5 period, R6/R11 frame, R3/R7/R8 op and enable
            check(busy_cycles == 64 * per, "R1 busy length", busy_cycles, 64 * per);
            check(rise_t1 - rise_t0 == per, code[2] ? "R5 reserved period" : "R4 period",
                  rise_t1 - rise_t0, per);
            check((cap_o & mask) == (ef & mask), "R6 R11 R3 frame bits", cap_o & mask,
                  ef & mask);
            check(cap_oe == eoe, wr ? "R7 write enable" : "R8 read release", cap_oe, eoe);
            check(!mdc && !mdio_oe, "R10 idle after frame", {mdc, mdio_oe}, 0);
            if (!wr) check(dat_rdata == rp, "R9 R8 read data", dat_rdata, rp);
            else     check(dat_rdata == wd, "R3 write keeps data", dat_rdata, wd);
        end

        // R2: writes during busy ignored
        @(negedge clk);
        dat_we = 1'b1; dat_wdata = 16'h3C3C;
        @(negedge clk);
        dat_we = 1'b0;
        run_xfer({5'h09, 5'h06, 1'b0, 3'b010, 1'b1, 1'b1}, 16'h0, 1'b1);
        check(cfg_rdata == {5'h09, 5'h06, 1'b0, 3'b010, 1'b1, 1'b0}, "R2 cfg locked",
              cfg_rdata, {5'h09, 5'h06, 1'b0, 3'b010, 1'b1, 1'b0});
        check(dat_rdata == 16'h3C3C, "R2 data locked", dat_rdata, 16'h3C3C);
        check(cap_o == exp_frame(1'b1, 5'h09, 5'h06, 16'h3C3C), "R2 frame unchanged",
              cap_o, exp_frame(1'b1, 5'h09, 5'h06, 16'h3C3C));
        check(busy_cycles == 64 * 16, "R2 no restart", busy_cycles, 64 * 16);

        // R12: field update without start
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = {5'h11, 5'h1E, 1'b0, 3'b011, 1'b0, 1'b0};
        @(negedge clk);
        cfg_we = 1'b0;
        begin
            bit quiet = 1'b1;
            for (int i = 0; i < 60; i++) begin
                if (mdc || mdio_oe || cfg_rdata[0]) quiet = 1'b0;
                @(negedge clk);
            end
            check(quiet, "R12 no transfer", 0, 0);
        end
        check(cfg_rdata == {5'h11, 5'h1E, 1'b0, 3'b011, 1'b0, 1'b0}, "R12 fields updated",
              cfg_rdata, {5'h11, 5'h1E, 1'b0, 3'b011, 1'b0, 1'b0});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule